// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Add-One Conversion

This block is a purely combinational binary adder. It takes two WIDTH-bit operands and a carry-in, and returns the WIDTH-bit sum and the carry-out. It is meant for datapaths where a plain ripple adder is too slow and a full dual-ripple carry-select adder costs too much area.

The operand is split into groups, and the groups widen toward the most significant end. The lowest group is a ripple-carry adder driven by the external carry-in. Every higher group runs a single ripple adder that assumes its carry-in is zero. It derives the carry-in-one result by passing that zero-case value through an add-one converter. The actual carry arriving from the group below then picks one of the two results with a 2-to-1 multiplexer. Both candidates of a group settle in parallel with the lower groups, so only the selection sits on the long carry path.

The group schedule is computed from WIDTH. The widths are 2, 2, 3, 4, 5 and so on, each group one bit wider than the one before it after the first two. The top group is cut short so the widths add up to WIDTH exactly.

Top module: `sqrt_csla`

## Requirements
- R1: For every input, `{cout_o, sum_o}` equals the (WIDTH+1)-bit value `a_i + b_i + cin_i`.
- R2: With `a_i` all ones, `b_i` zero and `cin_i` = 1, the sum is zero and `cout_o` is 1.
- R3: With `a_i` all ones, `b_i` = 1 and `cin_i` = 0, the sum is zero and `cout_o` is 1, so the carry crosses every group.
- R4: In each upper group, the carry-in-one candidate `{carry, sum}` equals the carry-in-zero candidate plus one, modulo 2^(k+1) for a group of width k. The converter inverts bit 0 and XORs each higher bit with the AND of all bits below it.
- R5: Group widths, counted from bit 0, are 2, 2, then 3, 4, 5 and so on, with the top group cut to fit. For WIDTH = 16 the groups are 2, 2, 3, 4, 5. A run of ones of any length L plus one gives `2^L` for every L up to WIDTH, so the carry is correct across each group boundary.
- R6: An upper group's carry-out is chosen by the same selection as its sum bits. A group whose zero-case sum is all ones without a carry produces a carry-out when its incoming carry is 1.
- R7: Zero plus zero with `cin_i` = 0 gives a zero sum and `cout_o` = 0.
- R8: The adder elaborates and meets R1 at WIDTH = 8, 16, 32, 64 and 128.
- R9: The lowest group adds the low operand bits plus `cin_i` directly, and its carry-out feeds the first selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
A fault in one group's add-one converter or selector corrupts only the sum bits of that group, plus the carry passed to the groups above it. It does so only when that group's incoming carry takes the value that picks the faulty candidate. Because the block is combinational, the error shows at the ports within the same cycle as the stimulus. Runs of ones of every length force a carry into each group boundary, so every selector sees both carry values. Alternating bit patterns and random operands exercise the converter's prefix-AND terms in the middle of each group.

// File: rtl/csla_pkg.sv
package csla_pkg;

  // Width of group g for an n-bit adder: 2, 2, 3, 4, 5, ... with the top cut to fit.
  function automatic int grp_width(input int n, input int g);
    int used;
    int w;
    used = 0;
    w = 0;
    for (int i = 0; i <= g; i++) begin
      w = (i < 2) ? 2 : i + 1;
      if (used + w > n) w = n - used;
      if (w < 0) w = 0;
      used = used + w;
    end
    return w;
  endfunction

  // Lowest bit index of group g.
  function automatic int grp_lsb(input int n, input int g);
    int acc;
    acc = 0;
    for (int i = 0; i < g; i++) acc = acc + grp_width(n, i);
    return acc;
  endfunction

  // Number of groups needed to cover n bits.
  function automatic int grp_count(input int n);
    int used;
    int cnt;
    used = 0;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (used < n) begin
        used = used + grp_width(n, i);
        cnt = cnt + 1;
      end
    end
    return cnt;
  endfunction

endpackage

// File: rtl/csla_rca.sv
module csla_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] chain;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : gen_fa
    assign sum_o[i]     = a_i[i] ^ b_i[i] ^ chain[i];
    assign chain[i + 1] = (a_i[i] & b_i[i]) | (chain[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = chain[W];

  // R1/R9: the ripple stage is an exact adder.
  always_comb begin
    a_r1_rca_exact: assert ({cout_o, sum_o} ==
                            ({1'b0, a_i} + {1'b0, b_i} + (W + 1)'(cin_i)))
      else $error("ripple stage result wrong");
  end
endmodule

// File: rtl/csla_bec.sv
module csla_bec #(
  parameter int W = 5
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] inc_o
);
  logic [W-1:0] below_ones;

  assign below_ones[0] = 1'b1;
  assign inc_o[0]      = ~val_i[0];

  for (genvar i = 1; i < W; i++) begin : gen_bit
    assign below_ones[i] = below_ones[i - 1] & val_i[i - 1];
    assign inc_o[i]      = val_i[i] ^ below_ones[i];
  end

  // R4: the converter output is the input plus one, wrapping at W bits.
  always_comb begin
    a_r4_add_one: assert (inc_o == W'(val_i + W'(1)))
      else $error("add-one converter wrong");
  end
endmodule

// File: rtl/csla_group.sv
module csla_group #(
  parameter int W = 3
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] sum_zero;
  logic         carry_zero;
  logic [W:0]   cand_one;

  csla_rca #(.W(W)) u_rca (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (1'b0),
    .sum_o (sum_zero),
    .cout_o(carry_zero)
  );

  csla_bec #(.W(W + 1)) u_bec (
    .val_i({carry_zero, sum_zero}),
    .inc_o(cand_one)
  );

  assign {cout_o, sum_o} = cin_i ? cand_one : {carry_zero, sum_zero};

  // R6: the selected carry and sum together form the exact group sum.
  always_comb begin
    a_r6_group_select: assert ({cout_o, sum_o} ==
                               ({1'b0, a_i} + {1'b0, b_i} + (W + 1)'(cin_i)))
      else $error("group selection wrong");
  end
endmodule

// File: rtl/sqrt_csla.sv
module sqrt_csla #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  import csla_pkg::*;

  localparam int NG = grp_count(WIDTH);
  localparam int W0 = grp_width(WIDTH, 0);

  for (genvar g = 0; g < NG; g++) begin : gen_grp
    localparam int LSB = grp_lsb(WIDTH, g);
    localparam int GW  = grp_width(WIDTH, g);
    logic co;
    if (g == 0) begin : gen_low
      csla_rca #(.W(GW)) u_low (
        .a_i   (a_i[LSB +: GW]),
        .b_i   (b_i[LSB +: GW]),
        .cin_i (cin_i),
        .sum_o (sum_o[LSB +: GW]),
        .cout_o(co)
      );
    end else begin : gen_sel
      csla_group #(.W(GW)) u_sel (
        .a_i   (a_i[LSB +: GW]),
        .b_i   (b_i[LSB +: GW]),
        .cin_i (gen_grp[g - 1].co),
        .sum_o (sum_o[LSB +: GW]),
        .cout_o(co)
      );
    end
  end

  // Carry leaving the lowest group, named for the assertion below.
  logic low_carry;
  assign low_carry = gen_grp[0].co;
  assign cout_o    = gen_grp[NG - 1].co;

  always_comb begin
    // R9: the lowest group adds its bits plus the external carry-in.
    a_r9_low_group: assert ({low_carry, sum_o[W0-1:0]} ==
                            ({1'b0, a_i[W0-1:0]} + {1'b0, b_i[W0-1:0]} + (W0 + 1)'(cin_i)))
      else $error("lowest group wrong");
    // R1: whole-word result.
    a_r1_full_sum: assert ({cout_o, sum_o} ==
                           ({1'b0, a_i} + {1'b0, b_i} + (WIDTH + 1)'(cin_i)))
      else $error("adder result wrong");
  end
endmodule

// File: tb/sqrt_csla_tb.sv
module sqrt_csla_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [127:0] opa, opb;
  logic         ci;

  logic [15:0]  s16;  logic c16;
  logic [7:0]   s8;   logic c8;
  logic [31:0]  s32;  logic c32;
  logic [63:0]  s64;  logic c64;
  logic [127:0] s128; logic c128;

  sqrt_csla #(.WIDTH(16)) u_dut (
    .a_i(opa[15:0]), .b_i(opb[15:0]), .cin_i(ci), .sum_o(s16), .cout_o(c16));
  sqrt_csla #(.WIDTH(8)) u_w8 (
    .a_i(opa[7:0]), .b_i(opb[7:0]), .cin_i(ci), .sum_o(s8), .cout_o(c8));
  sqrt_csla #(.WIDTH(32)) u_w32 (
    .a_i(opa[31:0]), .b_i(opb[31:0]), .cin_i(ci), .sum_o(s32), .cout_o(c32));
  sqrt_csla #(.WIDTH(64)) u_w64 (
    .a_i(opa[63:0]), .b_i(opb[63:0]), .cin_i(ci), .sum_o(s64), .cout_o(c64));
  sqrt_csla #(.WIDTH(128)) u_w128 (
    .a_i(opa), .b_i(opb), .cin_i(ci), .sum_o(s128), .cout_o(c128));

  // Expected w+1 bit result, computed by masking a 129-bit integer sum.
  function automatic logic [128:0] ref_add(input logic [127:0] a, input logic [127:0] b,
                                           input logic c, input int w);
    logic [128:0] m;
    logic [128:0] r;
    m = (129'(1) << w) - 129'(1);
    r = (129'(a) & m) + (129'(b) & m) + 129'(c);
    return r & ((m << 1) | 129'(1));
  endfunction

  task automatic cmp(input string req, input int w, input logic [128:0] got,
                     input logic [128:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s width=%0d a=%h b=%h cin=%b actual=%h expected=%h",
               req, w, opa, opb, ci, got, exp);
    end
  endtask

  // Apply one vector to all instances, then compare at the falling edge.
  task automatic apply(input logic [127:0] a, input logic [127:0] b, input logic c,
                       input string req);
    @(posedge clk);
    opa = a; opb = b; ci = c;
    @(negedge clk);
    cmp(req, 16,  129'({c16, s16}),   ref_add(a, b, c, 16));
    cmp(req, 8,   129'({c8, s8}),     ref_add(a, b, c, 8));
    cmp(req, 32,  129'({c32, s32}),   ref_add(a, b, c, 32));
    cmp(req, 64,  129'({c64, s64}),   ref_add(a, b, c, 64));
    cmp(req, 128, 129'({c128, s128}), ref_add(a, b, c, 128));
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  logic [127:0] ones = '1;
  logic [127:0] alt  = {32{4'h5}};

  initial begin
    opa = '0; opb = '0; ci = 1'b0;
    void'($urandom(32'd2014));
    // R7: zero plus zero.
    apply('0, '0, 1'b0, "R7");
    // R2: all ones plus carry-in.
    apply(ones, '0, 1'b1, "R2");
    // R3: all ones plus one.
    apply(ones, 128'd1, 1'b0, "R3");
    // R1/R4: alternating patterns with both carry-in values.
    apply(alt, ~alt, 1'b0, "R1");
    apply(alt, ~alt, 1'b1, "R4");
    apply(alt, alt, 1'b1, "R4");
    apply(~alt, ~alt, 1'b0, "R1");
    // R5/R6: runs of ones of every length plus one, reaching every group boundary.
    for (int len = 1; len <= 128; len++) begin
      apply((128'd1 << len) - 128'd1, 128'd1, 1'b0, "R5");
      apply((128'd1 << len) - 128'd1, '0, 1'b1, "R6");
    end
    // R9: carry-in reaching the low group with low bits set.
    apply(128'h3, '0, 1'b1, "R9");
    apply(128'h1, 128'h2, 1'b1, "R9");
    // R1/R8: random operands at all widths.
    for (int i = 0; i < 1500; i++) begin
      apply({$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom},
            1'($urandom), "R8");
    end
    report();
  end

  initial begin
    #3_000_000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end
endmodule